// File: doc/BRIEF.md
# Secure Region Configuration Register Bank

This block is the programmable state of a memory protection controller. A 32-bit register bus writes and reads it. Each bus access carries a security attribute and an access size. The bank holds a control word, an index pointer and a table of 32-bit words. Each bit of a table word marks one memory block as secure (0) or non-secure (1). The bank also holds a one-bit interrupt status, which is set and cleared by writing to separate registers, together with its enable bit and twelve read-only identification bytes.

The transaction filter that sits beside this bank reads the table through `lut_flat`, along with the control bits and the interrupt enable. Software reaches the table through a single window register, which selects a word using the index. The index can step forward on its own, so software can stream the whole table with word accesses. A lockdown bit freezes the protection setup until the next reset. Non-secure software can only see the identification bytes.

Top module: `sec_cfg_regs`

## Requirements
- R1: The control register (offset 0x00) keeps only bit 4 (error response), bit 8 (index auto-step) and bit 31 (lockdown). All other bits read 0, and writes to them are dropped.
- R2: After reset, control reads 0x0000_0100, the index reads 0, the status reads 0, the enable reads 1 and every table word is 0.
- R3: Offset 0x10 reads TBL_WORDS-1. Offset 0x14 reads BLK_LOG2-5.
- R4: A write to the index (0x18) stores the written value modulo TBL_WORDS. Offset 0x1C reads or writes table word [index]. Table word i appears on `lut_flat[32*i+31:32*i]`.
- R5: When auto-step is 1, each word-size secure access to 0x1C (read, or write that is not locked) moves the index up by one. After TBL_WORDS-1 the index wraps to 0. Byte and halfword accesses leave the index unchanged.
- R6: While lockdown is 1, writes to 0x00, 0x1C and 0x28 are ignored. Only a reset clears lockdown.
- R7: A non-secure access (`pns`=1) to any offset below 0xFD0 reads 0 and changes nothing.
- R8: Offsets 0xFD0 to 0xFFC read, in offset order, the bytes 04 00 00 00 60 B8 1B 00 0D F0 05 B1. Both worlds can read them, and writes to them are ignored.
- R9: Writing 1 to bit 0 of 0x34 sets the status (read at 0x20). Writing 1 to bit 0 of 0x24 clears it. Offset 0x28 holds the 1-bit enable. Offsets 0x24 and 0x34 read 0.
- R10: The access size is encoded on `psize` as 00 byte, 01 halfword, 1x word. The lane is given by `paddr[1:0]`, and write data sits in the low bits of `pwdata`. A sub-word write to 0x00, 0x18 or 0x1C is merged into the current value. A sub-word write to any other register is padded with zeros to a full word.
- R11: A sub-word read returns the addressed lane of the register, right-aligned, with the upper bits at 0.
- R12: An unmapped offset reads 0. The bus never stalls and never signals an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address |
| psize | input | 2 | Access size: 00 byte, 01 half, 1x word |
| pns | input | 1 | 1 = non-secure access |
| pwdata | input | 32 | Write data, right-aligned |
| prdata | output | 32 | Read data, right-aligned, valid in access phase |
| lut_flat | output | 32*TBL_WORDS | Table contents for the filter |
| ctrl_err_resp | output | 1 | Error response on violation |
| ctrl_autoinc | output | 1 | Index auto-step enable |
| ctrl_lock | output | 1 | Lockdown |
| irq_en | output | 1 | Interrupt enable |

## Verification
The assertions run on every cycle and cover four things: lockdown never drops and keeps the table, the control bits and the enable frozen; non-secure accesses below the identification area read zero and leave the exported state unchanged; the set and clear registers read zero; and control reads and size reads show no reserved bits. Only the bench scenarios can show the rest. That covers index wrap and auto-step order across word and sub-word accesses, the merge-versus-zero-padding split for partial writes, and the identification bytes. It also covers lockdown being released only by reset. The bench compares each of these against a reference model.

// File: rtl/sec_cfg_regs.sv
module sec_cfg_regs #(
  parameter int TBL_WORDS = 6,
  parameter int BLK_LOG2  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [11:0]            paddr,
  input  logic [1:0]             psize,
  input  logic                   pns,
  input  logic [31:0]            pwdata,
  output logic [31:0]            prdata,
  output logic [32*TBL_WORDS-1:0] lut_flat,
  output logic                   ctrl_err_resp,
  output logic                   ctrl_autoinc,
  output logic                   ctrl_lock,
  output logic                   irq_en
);
  localparam int IDX_W = (TBL_WORDS > 1) ? $clog2(TBL_WORDS) : 1;
  localparam logic [31:0] CTRL_KEEP = 32'h8000_0110;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TBL_WORDS - 1);

  localparam logic [11:0] OFF_CTRL = 12'h000, OFF_NBLK = 12'h010, OFF_BCFG = 12'h014,
                          OFF_IDX  = 12'h018, OFF_WIN  = 12'h01C, OFF_STAT = 12'h020,
                          OFF_CLR  = 12'h024, OFF_EN   = 12'h028, OFF_SET  = 12'h034,
                          OFF_ID0  = 12'hFD0;

  logic [31:0]      ctrl_q;
  logic [IDX_W-1:0] idx_q;
  logic             stat_q, en_q;
  logic [31:0]      lut_q [TBL_WORDS];

  wire        acc     = psel & penable;
  wire        wr      = acc & pwrite;
  wire        rd      = acc & ~pwrite;
  wire [11:0] off     = {paddr[11:2], 2'b00};
  wire        blocked = pns & (paddr < OFF_ID0);
  wire        full    = psize[1];
  wire [4:0]  sh      = {paddr[1:0], 3'b000};
  wire [31:0] wmask_r = full ? 32'hFFFF_FFFF : (psize[0] ? 32'h0000_FFFF : 32'h0000_00FF);
  wire [31:0] lmask   = wmask_r << sh;
  wire [31:0] cur_win = lut_q[idx_q];
  wire        locked  = ctrl_q[31];

  logic [31:0] old_v, wval, rword;

  always_comb begin
    case (off)
      OFF_CTRL: old_v = ctrl_q;
      OFF_IDX:  old_v = 32'(idx_q);
      OFF_WIN:  old_v = cur_win;
      default:  old_v = 32'h0;
    endcase
  end

  assign wval = (old_v & ~lmask) | ((pwdata << sh) & lmask);

  wire wr_ok   = wr & ~blocked;
  wire wr_lockable = (off == OFF_CTRL) | (off == OFF_WIN) | (off == OFF_EN);
  wire wr_go   = wr_ok & ~(locked & wr_lockable);
  wire win_acc = (off == OFF_WIN) & ((rd & ~blocked) | wr_go);
  wire step    = win_acc & full & ctrl_q[8];

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:  id_byte = 8'h04;
      4'd4:  id_byte = 8'h60;
      4'd5:  id_byte = 8'hB8;
      4'd6:  id_byte = 8'h1B;
      4'd8:  id_byte = 8'h0D;
      4'd9:  id_byte = 8'hF0;
      4'd10: id_byte = 8'h05;
      4'd11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

  wire [11:0] id_off = off - OFF_ID0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 32'h0000_0100;
      en_q   <= 1'b1;
      stat_q <= 1'b0;
    end else if (wr_go) begin
      case (off)
        OFF_CTRL: ctrl_q <= wval & CTRL_KEEP;
        OFF_EN:   en_q   <= wval[0];
        OFF_CLR:  if (wval[0]) stat_q <= 1'b0;
        OFF_SET:  if (wval[0]) stat_q <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (wr_go && off == OFF_IDX)
      idx_q <= IDX_W'(wval % 32'(TBL_WORDS));
    else if (step)
      idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_WORDS; i++) lut_q[i] <= 32'h0;
    end else if (wr_go && off == OFF_WIN) begin
      lut_q[idx_q] <= wval;
    end
  end

  always_comb begin
    rword = 32'h0;
    if (off >= OFF_ID0)
      rword = {24'h0, id_byte(id_off[5:2])};
    else
      case (off)
        OFF_CTRL: rword = ctrl_q;
        OFF_NBLK: rword = 32'(TBL_WORDS - 1);
        OFF_BCFG: rword = 32'(BLK_LOG2 - 5);
        OFF_IDX:  rword = 32'(idx_q);
        OFF_WIN:  rword = cur_win;
        OFF_STAT: rword = {31'h0, stat_q};
        OFF_EN:   rword = {31'h0, en_q};
        default:  rword = 32'h0;
      endcase
  end

  assign prdata = (rd && !blocked) ? ((rword >> sh) & wmask_r) : 32'h0;

  for (genvar g = 0; g < TBL_WORDS; g++) begin : g_flat
    assign lut_flat[32*g +: 32] = lut_q[g];
  end

  assign ctrl_err_resp = ctrl_q[4];
  assign ctrl_autoinc  = ctrl_q[8];
  assign ctrl_lock     = ctrl_q[31];
  assign irq_en        = en_q;
endmodule

// File: rtl/sec_cfg_regs_chk.sv
module sec_cfg_regs_chk #(
  parameter int TBL_WORDS = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    psel,
  input logic                    penable,
  input logic                    pwrite,
  input logic [11:0]             paddr,
  input logic [1:0]              psize,
  input logic                    pns,
  input logic [31:0]             prdata,
  input logic [32*TBL_WORDS-1:0] lut_flat,
  input logic                    ctrl_err_resp,
  input logic                    ctrl_autoinc,
  input logic                    ctrl_lock,
  input logic                    irq_en
);
  wire rd_c   = psel && penable && !pwrite;
  wire wr_c   = psel && penable && pwrite;
  wire low_ns = pns && (paddr < 12'hFD0);
  wire word0  = psize[1] && (paddr[1:0] == 2'b00);

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_lock |=> ctrl_lock);

  assert_lock_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_lock |=> ($stable(lut_flat) && $stable(irq_en) && $stable(ctrl_err_resp) && $stable(ctrl_autoinc)));

  assert_ns_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && low_ns) |-> (prdata == 32'h0));

  assert_ns_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && low_ns) |=> ($stable(lut_flat) && $stable(irq_en) && $stable(ctrl_lock)
                          && $stable(ctrl_err_resp) && $stable(ctrl_autoinc)));

  assert_setclr_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !pns && (paddr[11:2] == 10'h009 || paddr[11:2] == 10'h00D)) |-> (prdata == 32'h0));

  assert_ctrl_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !pns && word0 && paddr[11:2] == 10'h000) |-> ((prdata & ~32'h8000_0110) == 32'h0));

  assert_nblk_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && word0 && paddr[11:2] == 10'h004 && !pns) |-> (prdata == 32'(TBL_WORDS - 1)));
endmodule

bind sec_cfg_regs sec_cfg_regs_chk #(.TBL_WORDS(TBL_WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .psize(psize), .pns(pns), .prdata(prdata), .lut_flat(lut_flat),
  .ctrl_err_resp(ctrl_err_resp), .ctrl_autoinc(ctrl_autoinc), .ctrl_lock(ctrl_lock),
  .irq_en(irq_en)
);

// File: tb/sec_cfg_regs_tb_top.sv
module sec_cfg_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 6;
  localparam int BL = 12;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, pns = 0;
  logic [11:0] paddr = '0;
  logic [1:0]  psize = 2'b10;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [32*W-1:0] lut_flat;
  logic ctrl_err_resp, ctrl_autoinc, ctrl_lock, irq_en;

  int checks = 0, failures = 0;

  logic [31:0] m_ctrl, m_idx, m_lut [W];
  logic        m_stat, m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_cfg_regs #(.TBL_WORDS(W), .BLK_LOG2(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .psize(psize), .pns(pns), .pwdata(pwdata), .prdata(prdata),
    .lut_flat(lut_flat), .ctrl_err_resp(ctrl_err_resp), .ctrl_autoinc(ctrl_autoinc),
    .ctrl_lock(ctrl_lock), .irq_en(irq_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] szmask(input logic [1:0] sz);
    return sz[1] ? 32'hFFFF_FFFF : (sz[0] ? 32'h0000_FFFF : 32'h0000_00FF);
  endfunction

  function automatic logic [7:0] m_id(input int k);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h60, 8'hB8, 8'h1B, 8'h00,
                           8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  task automatic m_reset();
    m_ctrl = 32'h100; m_idx = 0; m_stat = 0; m_en = 1;
    for (int i = 0; i < W; i++) m_lut[i] = 0;
  endtask

  task automatic m_step();
    m_idx = (m_idx + 1) % W;
  endtask

  function automatic logic [31:0] m_rd(input logic [11:0] a, input logic [1:0] sz, input logic ns);
    logic [11:0] o = {a[11:2], 2'b00};
    logic [31:0] r = 0;
    if (ns && o < 12'hFD0) return 0;
    if (o >= 12'hFD0) r = {24'h0, m_id((o - 12'hFD0) / 4)};
    else if (o == 12'h000) r = m_ctrl;
    else if (o == 12'h010) r = W - 1;
    else if (o == 12'h014) r = BL - 5;
    else if (o == 12'h018) r = m_idx;
    else if (o == 12'h01C) r = m_lut[m_idx];
    else if (o == 12'h020) r = {31'h0, m_stat};
    else if (o == 12'h028) r = {31'h0, m_en};
    return (r >> (8 * a[1:0])) & szmask(sz);
  endfunction

  task automatic m_rd_side(input logic [11:0] a, input logic [1:0] sz, input logic ns);
    if (!ns && {a[11:2], 2'b00} == 12'h01C && sz[1] && m_ctrl[8]) m_step();
  endtask

  task automatic m_wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz, input logic ns);
    logic [11:0] o = {a[11:2], 2'b00};
    logic [31:0] old = 0, mk, v;
    if (ns && o < 12'hFD0) return;
    if (o == 12'h000) old = m_ctrl;
    if (o == 12'h018) old = m_idx;
    if (o == 12'h01C) old = m_lut[m_idx];
    mk = szmask(sz) << (8 * a[1:0]);
    v  = (old & ~mk) | ((d << (8 * a[1:0])) & mk);
    if (m_ctrl[31] && (o == 12'h000 || o == 12'h01C || o == 12'h028)) return;
    case (o)
      12'h000: m_ctrl = v & 32'h8000_0110;
      12'h018: m_idx  = v % W;
      12'h01C: begin m_lut[m_idx] = v; if (sz[1] && m_ctrl[8]) m_step(); end
      12'h024: if (v[0]) m_stat = 0;
      12'h028: m_en = v[0];
      12'h034: if (v[0]) m_stat = 1;
      default: ;
    endcase
  endtask

  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [1:0] sz, input logic ns, output logic [31:0] r);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d; psize = sz; pns = ns;
    @(negedge clk);
    penable = 1;
    #1 r = prdata;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz, input logic ns);
    logic [31:0] r;
    bus(1, a, d, sz, ns, r);
    m_wr(a, d, sz, ns);
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [1:0] sz, input logic ns);
    logic [31:0] r, e;
    e = m_rd(a, sz, ns);
    bus(0, a, 0, sz, ns, r);
    m_rd_side(a, sz, ns);
    chk(tag, r, e);
  endtask

  task automatic chk_outs(input string tag);
    for (int i = 0; i < W; i++) chk({tag, " lut_flat"}, lut_flat[32*i +: 32], m_lut[i]);
    chk({tag, " ctrl"}, {29'h0, ctrl_lock, ctrl_autoinc, ctrl_err_resp},
        {29'h0, m_ctrl[31], m_ctrl[8], m_ctrl[4]});
    chk({tag, " irq_en"}, {31'h0, irq_en}, {31'h0, m_en});
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] offs [14] = '{12'h000, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h01C, 12'h020,
                              12'h024, 12'h028, 12'h034, 12'h040, 12'hFD0, 12'hFE4, 12'hFFC};
    void'($urandom(32'h5EC0_0001));
    m_reset();
    do_reset();

    // R2 reset state
    @(negedge clk);
    chk_outs("R2");
    rd("R2 ctrl", 12'h000, 2'b10, 0);
    rd("R2 idx", 12'h018, 2'b10, 0);
    rd("R2 stat", 12'h020, 2'b10, 0);
    rd("R2 en", 12'h028, 2'b10, 0);
    rd("R2 win", 12'h01C, 2'b10, 0);

    // R3 geometry
    rd("R3 nblk", 12'h010, 2'b10, 0);
    rd("R3 bcfg", 12'h014, 2'b10, 0);

    // R1 reserved bits
    wr(12'h000, 32'h7FFF_FFFF, 2'b10, 0);
    rd("R1 ctrl mask", 12'h000, 2'b10, 0);

    // R4 modulo index and window
    wr(12'h018, 32'd17, 2'b10, 0);
    rd("R4 idx mod", 12'h018, 2'b10, 0);
    wr(12'h000, 32'h0, 2'b10, 0);
    wr(12'h01C, 32'hCAFE_0005, 2'b10, 0);
    rd("R4 win", 12'h01C, 2'b10, 0);
    @(negedge clk); chk_outs("R4");

    // R5 wrap and sub-word no-step
    wr(12'h000, 32'h100, 2'b10, 0);
    wr(12'h018, W - 1, 2'b10, 0);
    rd("R5 win word", 12'h01C, 2'b10, 0);
    rd("R5 wrap idx", 12'h018, 2'b10, 0);
    rd("R5 win byte", 12'h01D, 2'b00, 0);
    rd("R5 no step", 12'h018, 2'b10, 0);

    // R10 merge vs zero pad
    wr(12'h01C, 32'h00AB, 2'b00, 0);
    wr(12'h01E, 32'h1234, 2'b01, 0);
    rd("R10 merged win", 12'h01C, 2'b10, 0);
    wr(12'h035, 32'h01, 2'b00, 0);
    rd("R10 zero pad set", 12'h020, 2'b10, 0);
    wr(12'h001, 32'h00, 2'b00, 0);
    rd("R10 ctrl merge", 12'h000, 2'b10, 0);

    // R7 non-secure gating
    wr(12'h028, 32'h0, 2'b10, 1);
    rd("R7 ns en", 12'h028, 2'b10, 1);
    rd("R7 en kept", 12'h028, 2'b10, 0);
    rd("R8 ns id", 12'hFD4, 2'b10, 1);
    wr(12'hFD0, 32'hFF, 2'b10, 0);
    rd("R8 id kept", 12'hFD0, 2'b10, 0);

    // R9 set/clear
    wr(12'h034, 1, 2'b10, 0);
    rd("R9 set", 12'h020, 2'b10, 0);
    rd("R9 set reads 0", 12'h034, 2'b10, 0);
    wr(12'h024, 1, 2'b10, 0);
    rd("R9 clr", 12'h020, 2'b10, 0);

    // R11/R12 lanes and unmapped
    rd("R11 id lane", 12'hFD5, 2'b00, 0);
    rd("R12 unmapped", 12'h044, 2'b10, 0);

    // random phase (no lockdown)
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a; logic [1:0] sz; logic ns; logic [31:0] d; logic [1:0] ln;
      a  = offs[$urandom % 14];
      sz = 2'($urandom % 3);
      if (sz == 2'b10) ln = 0; else if (sz == 2'b01) ln = 2'($urandom % 2) << 1; else ln = 2'($urandom % 4);
      a  = a | {10'h0, ln};
      ns = ($urandom % 4) == 0;
      d  = $urandom;
      if (a[11:2] == 10'h000) d = d & ~(32'h1 << (31 - 8 * ln));
      if ($urandom % 2) wr(a, d, sz, ns);
      else rd("R4 R5 R7 R11 random", a, sz, ns);
      @(negedge clk); chk_outs("R10 random");
    end

    // R6 lockdown
    wr(12'h000, 32'h8000_0010, 2'b10, 0);
    wr(12'h000, 32'h0, 2'b10, 0);
    wr(12'h01C, 32'hDEAD_BEEF, 2'b10, 0);
    wr(12'h028, 32'h0, 2'b10, 0);
    @(negedge clk); chk_outs("R6 locked");
    rd("R6 ctrl", 12'h000, 2'b10, 0);
    wr(12'h018, 32'd2, 2'b10, 0);
    rd("R6 idx writable", 12'h018, 2'b10, 0);
    wr(12'h034, 1, 2'b10, 0);
    rd("R6 stat writable", 12'h020, 2'b10, 0);
    do_reset();
    @(negedge clk); chk_outs("R6 after reset");
    rd("R6 unlocked", 12'h000, 2'b10, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule